// File: doc/BRIEF.md
# Timestamped Input-Event Capture FIFO

This block watches four digital input pins and turns every recognised rising edge into a record. A record holds the value of a free-running 16-bit timer at the moment of sampling and a 4-bit mask of the pins that rose. Several enabled pins that rise in the same sample share one record and one timestamp. Records queue in a seven-entry FIFO. One record at a time moves from the FIFO into a holding register, and software reads it through a small register port.

Three edge-triggered interrupt pulses report progress. The data-available pulse fires when the holding register is loaded. The fourth-entry pulse fires when the FIFO, not counting the holding register, reaches four entries. The full pulse fires when the FIFO reaches six entries. A source-select bit can move the data-available line over to the full condition. A separate pulse reports every rising edge on pin 0, whether or not that pin is enabled for capture. Test-mode writes preload the holding register and its event bits.

The register port has three addresses, all 16 bits wide:
- 0 is the time register.
- 1 is the status register. Bits [3:0] are the event mask of the held record, bits [7:4] the live sampled pins, bit 8 holding-valid, bit 9 the sticky data-available flag and bit 10 the sticky full flag.
- 2 is the control register. Bits [3:0] enable the pins and bit 4 is the source select.

The holding register is run by a three-state machine:
- HS_EMPTY: the holding register is empty. The move to HS_XFER is taken when the FIFO is not empty.
- HS_XFER: a transfer delay runs. The move to HS_FULL is taken when the delay ends, which pops the FIFO.
- HS_FULL: a record is held. The move to HS_EMPTY is taken on a read of the time register.

A test write to the time register moves the machine to HS_FULL from any state.

Top module: `tstamp_capture`

## Requirements
- R1: Pins pass through a two-flop synchroniser and are then sampled once every STATE_DIV (default 4) clocks. A rising edge on an enabled pin produces one record, provided the level is held for at least STATE_DIV clocks. A rising edge on a disabled pin produces no record.
- R2: Enabled pins that rise in the same sample produce a single record. Its mask has a 1 for each of those pins, and its timestamp is the timer value at that sample.
- R3: When the holding register is empty and the FIFO is not, the oldest record moves into the holding register after XFER_DELAY (default 3) clocks. Reading address 0 returns the held timestamp and empties the holding register. Status bit 8 shows whether the holding register is valid.
- R4: With source select (control bit 4) at 0, every load of the holding register gives one data-available pulse. While the holding register stays occupied, no further pulse is given.
- R5: With source select at 1, holding-register loads give no data-available pulse. The data-available line instead pulses when the FIFO count rises to 6 or more.
- R6: The fourth-entry pulse fires once when the FIFO count, not counting the holding register, rises from below 4 to 4 or more.
- R7: The full pulse fires when the FIFO count rises to 6 or more. It fires again only after the count has fallen to 5 or less and then risen back to 6.
- R8: Status bit 9 records a data-available pulse and status bit 10 records a full pulse. Both stay set until the status register is read, and that read clears them.
- R9: Status bits [7:4] always show the sampled pin levels, even when the holding register is empty and the pins are disabled.
- R10: A write to address 0 loads the holding register's timestamp and marks it valid. A write to address 1 loads the event mask bits [3:0] from the write data and leaves the live pin bits unchanged.
- R11: A sampled rising edge on pin 0 gives a one-clock pin-0 pulse even when pin 0 is disabled for capture.
- R12: When the FIFO holds 7 records, a new record is dropped. The count stays at 7, and the records already queued are read out later in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 4 | Asynchronous event input pins |
| timer_in | input | 16 | Free-running timer value used as the timestamp |
| reg_addr | input | 2 | Register address: 0 time, 1 status, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_data_avail | output | 1 | Data-available interrupt pulse |
| irq_fourth | output | 1 | FIFO fourth-entry interrupt pulse |
| irq_full | output | 1 | FIFO full interrupt pulse |
| irq_pin0 | output | 1 | Pin-0 rising-edge interrupt pulse |

## Verification
The hardest situation to reach is the re-arming of the full interrupt. It needs a held record left unread while seven more records pile up behind it, an eighth arriving to be dropped, and then exactly two reads to bring the FIFO count down to five before one more event lifts it back to six. The stimulus leaves the holding register unread during a burst of nine spaced pin-1 pulses, each carrying a distinct timestamp. It then drains in two steps around a single extra pulse. The order of the timestamps read back shows both the drop and the second full pulse. The same burst is repeated with source select set, to show the data-available line following the full condition and not the loads.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        HS_EMPTY = 2'd0,
        HS_XFER  = 2'd1,
        HS_FULL  = 2'd2
    } hold_state_t;

    localparam logic [1:0] ADDR_TIME = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

endpackage

// File: rtl/tsc_sampler.sv
module tsc_sampler #(
    parameter int N   = 4,
    parameter int TW  = 16,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pins,
    input  logic [N-1:0]  en,
    input  logic [TW-1:0] timer,
    output logic [N-1:0]  live,
    output logic          evt_valid,
    output logic [N-1:0]  evt_mask,
    output logic [TW-1:0] evt_time,
    output logic          pin0_rise
);
    localparam int DW = $clog2(DIV + 1);

    logic [N-1:0]  sync1, sync2;
    logic [DW-1:0] div_q;
    logic          strobe;
    logic [N-1:0]  rises;

    assign strobe = (div_q == DW'(DIV - 1));
    assign rises  = sync2 & ~live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1     <= '0;
            sync2     <= '0;
            div_q     <= '0;
            live      <= '0;
            evt_valid <= 1'b0;
            evt_mask  <= '0;
            evt_time  <= '0;
            pin0_rise <= 1'b0;
        end else begin
            sync1 <= pins;
            sync2 <= sync1;
            div_q <= strobe ? '0 : div_q + 1'b1;
            if (strobe) begin
                live      <= sync2;
                evt_mask  <= rises & en;
                evt_valid <= |(rises & en);
                evt_time  <= timer;
                pin0_rise <= rises[0];
            end else begin
                evt_valid <= 1'b0;
                pin0_rise <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
    parameter int N     = 4,
    parameter int TW    = 16,
    parameter int DEPTH = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [N-1:0]                 push_mask,
    input  logic [TW-1:0]                push_time,
    input  logic                         pop,
    output logic [N-1:0]                 head_mask,
    output logic [TW-1:0]                head_time,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [N-1:0]  mem_mask [DEPTH];
    logic [TW-1:0] mem_time [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push   = push && (count != CW'(DEPTH));
    assign do_pop    = pop && (count != '0);
    assign head_mask = mem_mask[rp];
    assign head_time = mem_time[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_mask[wp] <= push_mask;
            mem_time[wp] <= push_time;
        end
    end
endmodule

// File: rtl/tsc_irq.sv
module tsc_irq #(
    parameter int CW     = 3,
    parameter int FOURTH = 4,
    parameter int FULL   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          load_evt,
    input  logic          src_sel,
    output logic          irq_da,
    output logic          irq_fourth,
    output logic          irq_full
);
    logic lvl_fourth, lvl_full, prev_fourth, prev_full, edge_full;

    assign lvl_fourth = (count >= CW'(FOURTH));
    assign lvl_full   = (count >= CW'(FULL));
    assign edge_full  = lvl_full & ~prev_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_fourth <= 1'b0;
            prev_full   <= 1'b0;
            irq_da      <= 1'b0;
            irq_fourth  <= 1'b0;
            irq_full    <= 1'b0;
        end else begin
            prev_fourth <= lvl_fourth;
            prev_full   <= lvl_full;
            irq_fourth  <= lvl_fourth & ~prev_fourth;
            irq_full    <= edge_full;
            irq_da      <= src_sel ? edge_full : load_evt;
        end
    end
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
    import tsc_pkg::*;
#(
    parameter int N           = 4,
    parameter int TW          = 16,
    parameter int RW          = 16,
    parameter int DEPTH       = 7,
    parameter int STATE_DIV   = 4,
    parameter int XFER_DELAY  = 3,
    parameter int FOURTH_TH   = 4,
    parameter int FULL_TH     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    pins_in,
    input  logic [15:0]   timer_in,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          irq_data_avail,
    output logic          irq_fourth,
    output logic          irq_full,
    output logic          irq_pin0
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int DLW = $clog2(XFER_DELAY + 1);

    hold_state_t    state, nxt;
    logic [DLW-1:0] dly_q;
    logic [N-1:0]   live, evt_mask, head_mask, hold_mask, pin_en;
    logic [TW-1:0]  evt_time, head_time, hold_time;
    logic           evt_valid, pin0_rise, src_sel;
    logic [CW-1:0]  fifo_cnt;
    logic           rd_time, rd_stat, wr_time, wr_stat, wr_ctrl;
    logic           fifo_pop, load_evt, hold_valid, dly_done;
    logic           flag_da, flag_full;

    assign rd_time = reg_rd && (reg_addr == ADDR_TIME);
    assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
    assign wr_time = reg_wr && (reg_addr == ADDR_TIME);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

    tsc_sampler #(.N(N), .TW(TW), .DIV(STATE_DIV)) u_samp (
        .clk(clk), .rst_n(rst_n), .pins(pins_in), .en(pin_en), .timer(timer_in),
        .live(live), .evt_valid(evt_valid), .evt_mask(evt_mask),
        .evt_time(evt_time), .pin0_rise(pin0_rise)
    );

    tsc_fifo #(.N(N), .TW(TW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(evt_valid), .push_mask(evt_mask),
        .push_time(evt_time), .pop(fifo_pop), .head_mask(head_mask),
        .head_time(head_time), .count(fifo_cnt)
    );

    tsc_irq #(.CW(CW), .FOURTH(FOURTH_TH), .FULL(FULL_TH)) u_irq (
        .clk(clk), .rst_n(rst_n), .count(fifo_cnt), .load_evt(load_evt),
        .src_sel(src_sel), .irq_da(irq_data_avail), .irq_fourth(irq_fourth),
        .irq_full(irq_full)
    );

    // Holding-register state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HS_EMPTY;
            dly_q <= '0;
        end else begin
            state <= nxt;
            dly_q <= (state == HS_XFER && nxt == HS_XFER) ? dly_q + 1'b1 : '0;
        end
    end

    // Next state and transfer outputs
    assign dly_done = (dly_q == DLW'(XFER_DELAY - 1));
    always_comb begin
        nxt      = state;
        fifo_pop = 1'b0;
        unique case (state)
            HS_EMPTY: if (fifo_cnt != '0) nxt = HS_XFER;
            HS_XFER:  if (dly_done) begin
                          nxt      = HS_FULL;
                          fifo_pop = !wr_time;
                      end
            HS_FULL:  if (rd_time) nxt = HS_EMPTY;
            default:  nxt = HS_EMPTY;
        endcase
        if (wr_time) nxt = HS_FULL;
        load_evt = fifo_pop || wr_time;
    end

    assign hold_valid = (state == HS_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_time <= '0;
            hold_mask <= '0;
            pin_en    <= '0;
            src_sel   <= 1'b0;
            flag_da   <= 1'b0;
            flag_full <= 1'b0;
        end else begin
            if (fifo_pop) begin
                hold_time <= head_time;
                hold_mask <= head_mask;
            end
            if (wr_time) hold_time <= reg_wdata[TW-1:0];
            if (wr_stat) hold_mask <= reg_wdata[N-1:0];
            if (wr_ctrl) begin
                pin_en  <= reg_wdata[N-1:0];
                src_sel <= reg_wdata[N];
            end
            flag_da   <= irq_data_avail | (flag_da & ~rd_stat);
            flag_full <= irq_full | (flag_full & ~rd_stat);
        end
    end

    assign irq_pin0 = pin0_rise;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_TIME: reg_rdata[TW-1:0] = hold_time;
            ADDR_STAT: begin
                reg_rdata[N-1:0]   = hold_mask;
                reg_rdata[2*N-1:N] = live;
                reg_rdata[2*N]     = hold_valid;
                reg_rdata[2*N+1]   = flag_da;
                reg_rdata[2*N+2]   = flag_full;
            end
            ADDR_CTRL: begin
                reg_rdata[N-1:0] = pin_en;
                reg_rdata[N]     = src_sel;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int CW     = 3,
    parameter int DEPTH  = 7,
    parameter int FOURTH = 4,
    parameter int FULL   = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_cnt,
    input logic          fifo_pop,
    input logic          hold_valid,
    input logic          src_sel,
    input logic          irq_da,
    input logic          irq_fourth,
    input logic          irq_full,
    input logic          irq_pin0
);
    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_cnt != '0);

    a_r3_pop_loads: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> hold_valid);

    a_r4_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_valid) && !$past(src_sel)) |-> irq_da);

    a_r6_fourth_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fourth |-> $past(fifo_cnt) >= CW'(FOURTH));

    a_r7_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full |-> $past(fifo_cnt) >= CW'(FULL));

    a_r7_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full |=> !irq_full);

    a_r11_pin0_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin0 |=> !irq_pin0);
endmodule

bind tstamp_capture tsc_checker #(
    .CW(CW), .DEPTH(DEPTH), .FOURTH(FOURTH_TH), .FULL(FULL_TH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .fifo_pop(fifo_pop),
    .hold_valid(hold_valid), .src_sel(src_sel), .irq_da(irq_data_avail),
    .irq_fourth(irq_fourth), .irq_full(irq_full), .irq_pin0(irq_pin0)
);

// File: tb/tb_tstamp_capture.sv
`timescale 1ns/1ps
module tb_tstamp_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins_in = '0;
    logic [15:0] timer_in = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_data_avail, irq_fourth, irq_full, irq_pin0;

    int n_chk = 0, n_fail = 0;
    int da_n = 0, four_n = 0, full_n = 0, p0_n = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tstamp_capture dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .timer_in(timer_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_data_avail(irq_data_avail), .irq_fourth(irq_fourth),
        .irq_full(irq_full), .irq_pin0(irq_pin0)
    );

    always @(negedge clk) if (rst_n) begin
        if (irq_data_avail) da_n++;
        if (irq_fourth)     four_n++;
        if (irq_full)       full_n++;
        if (irq_pin0)       p0_n++;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_pin(input logic [3:0] m, input logic [15:0] t, input int hold);
        @(negedge clk);
        timer_in = t; pins_in = m;
        repeat (hold) @(negedge clk);
        pins_in = '0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R3 reset status", 16'(irq_data_avail | irq_fourth | irq_full | irq_pin0), 16'h0);
        reg_read(2'd1, d); chk("R3 reset status", d, 16'h0000);
        reg_read(2'd2, d); chk("R3 reset ctrl", d, 16'h0000);
    endtask

    task automatic t_multi_pin;
        logic [15:0] d;
        int b;
        reg_write(2'd2, 16'h000F);
        b = da_n;
        pulse_pin(4'b0110, 16'h0100, 20);
        reg_read(2'd1, d); chk("R2 shared record mask+valid", d & 16'h010F, 16'h0106);
        reg_read(2'd0, d); chk("R2 shared timestamp", d, 16'h0100);
        chk("R4 one da pulse", 16'(da_n - b), 16'd1);
        reg_read(2'd1, d); chk("R3 holding empty after read", d & 16'h0100, 16'h0000);
        pulse_pin(4'b0001, 16'h0111, 4);
        reg_read(2'd1, d); chk("R1 min-width pulse captured", d & 16'h010F, 16'h0101);
        reg_read(2'd0, d); chk("R1 min-width timestamp", d, 16'h0111);
    endtask

    task automatic t_disabled;
        logic [15:0] d;
        int b;
        reg_write(2'd2, 16'h0001);
        pulse_pin(4'b0010, 16'h0200, 20);
        reg_read(2'd1, d); chk("R1 disabled pin no record", d & 16'h0100, 16'h0000);
        reg_write(2'd2, 16'h0000);
        b = p0_n;
        pulse_pin(4'b0001, 16'h0300, 20);
        chk("R11 pin0 pulse while disabled", 16'(p0_n - b), 16'd1);
        reg_read(2'd1, d); chk("R11 no record from pin0", d & 16'h0100, 16'h0000);
    endtask

    task automatic t_live;
        logic [15:0] d;
        @(negedge clk) pins_in = 4'b1010;
        repeat (20) @(negedge clk);
        reg_read(2'd1, d); chk("R9 live bits", d & 16'h01F0, 16'h00A0);
        pins_in = '0;
        repeat (20) @(negedge clk);
        reg_read(2'd1, d); chk("R9 live bits low", d & 16'h00F0, 16'h0000);
    endtask

    task automatic t_fill;
        logic [15:0] d;
        int bd, bf, bu;
        reg_write(2'd2, 16'h0002);
        reg_read(2'd1, d);
        bd = da_n; bf = four_n; bu = full_n;
        for (int i = 0; i < 9; i++) pulse_pin(4'b0010, 16'h1000 + 16'(i), 12);
        chk("R4 single da while held", 16'(da_n - bd), 16'd1);
        chk("R6 one fourth pulse", 16'(four_n - bf), 16'd1);
        chk("R7 one full pulse", 16'(full_n - bu), 16'd1);
        reg_read(2'd1, d); chk("R8 sticky flags set", d & 16'h070F, 16'h0702);
        reg_read(2'd1, d); chk("R8 sticky flags cleared", d & 16'h0600, 16'h0000);
        reg_read(2'd0, d); chk("R12 first record", d, 16'h1000);
        repeat (8) @(negedge clk);
        reg_read(2'd0, d); chk("R12 second record", d, 16'h1001);
        repeat (8) @(negedge clk);
        pulse_pin(4'b0010, 16'h2000, 12);
        chk("R7 full re-armed after drop to 5", 16'(full_n - bu), 16'd2);
        chk("R6 no second fourth pulse", 16'(four_n - bf), 16'd1);
        for (int i = 2; i < 8; i++) begin
            reg_read(2'd0, d); chk("R12 ordered drain", d, 16'h1000 + 16'(i));
            repeat (8) @(negedge clk);
        end
        reg_read(2'd0, d); chk("R12 ninth dropped, late record next", d, 16'h2000);
        repeat (8) @(negedge clk);
        reg_read(2'd1, d); chk("R12 nothing left", d & 16'h0100, 16'h0000);
    endtask

    task automatic t_srcsel;
        logic [15:0] d;
        int bd;
        reg_write(2'd2, 16'h0012);
        bd = da_n;
        pulse_pin(4'b0010, 16'h3000, 12);
        chk("R5 no da on load", 16'(da_n - bd), 16'd0);
        for (int i = 1; i < 7; i++) pulse_pin(4'b0010, 16'h3000 + 16'(i), 12);
        chk("R5 da follows full", 16'(da_n - bd), 16'd1);
        for (int i = 0; i < 7; i++) begin
            reg_read(2'd0, d);
            repeat (8) @(negedge clk);
        end
        chk("R5 no da on drain loads", 16'(da_n - bd), 16'd1);
        reg_write(2'd2, 16'h0000);
        reg_read(2'd1, d);
    endtask

    task automatic t_testwr;
        logic [15:0] d;
        @(negedge clk) pins_in = 4'b1000;
        repeat (20) @(negedge clk);
        reg_write(2'd1, 16'h00A3);
        reg_read(2'd1, d); chk("R10 status write keeps live", d & 16'h01FF, 16'h0083);
        reg_write(2'd0, 16'h1234);
        reg_read(2'd1, d); chk("R10 time write sets valid", d & 16'h0100, 16'h0100);
        reg_read(2'd0, d); chk("R10 time write value", d, 16'h1234);
        pins_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_multi_pin();
        t_disabled();
        t_live();
        t_fill();
        t_srcsel();
        t_testwr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule